// File: doc/BRIEF.md
# Serial Control Register Slave With Frame Alarms

This block is a serial-peripheral slave that holds the 16-bit control words of a mixed-signal front end. A host talks to it in fixed 24-bit frames, most significant bit first. Each frame is bracketed by an active-low select. It carries a read flag, a 6-bit register address, a 16-bit data word and a trailing bit that serves as a parity bit when parity is turned on. The serial pins are brought into the system clock domain through two-flop synchronisers and sampled in mode 0. The host drives MOSI before each rising SCLK edge and reads MISO at that edge.

A write lands only when the select rises at the end of a well-formed frame. A frame with the wrong clock count, an unimplemented address or (when enabled) a parity mismatch sets its own sticky bit in an alarm register. The host clears these bits by writing ones. A mask register chooses which alarm bits reach the interrupt pin. Register 0 carries a parity enable, a self-clearing soft reset and hard-wired identification fields. Every register's readable value is presented in parallel on `reg_image` for the analog control logic. The serial port has no back-pressure: the host paces the frames and the slave keeps up with any SCLK whose half period spans at least four system clocks.

Top module: `spirf_top`

## Requirements
- R1: A frame is 24 SCLK rising edges while `cs_n` is low, MSB first. Frame bit 23 is the read flag (1 = read), bits 22:17 are the address, bits 16:1 are the data and bit 0 is the parity bit. A write changes a register only after `cs_n` rises at the end of a valid frame; between frame ends `reg_image` does not change.
- R2: On a read frame, MISO carries register bits 15..0 at the rising edges that carry frame bits 16..1. MISO is 0 at all other edges, throughout write frames and whenever `cs_n` is high.
- R3: Addresses 0x00–0x05 and 0x07–0x0B are implemented. A 24-clock frame to any other address sets alarm bit 12 and changes nothing else. A read of such an address returns 0.
- R4: If the select rises after fewer than 24 clocks, alarm bit 14 is set and the frame's write is dropped.
- R5: If the select rises after more than 24 clocks, alarm bit 13 is set and the frame's write is dropped.
- R6: Register 0x00 bit 15 enables parity. When parity is enabled, the 24 frame bits must hold an odd number of ones. A mismatch sets alarm bit 15 and blocks the write. When parity is disabled, bit 0 is ignored.
- R7: Register 0x00 bits 11:4 read as the chip identifier (default 0x09) and bits 3:0 read as the revision (default 0x3). Writes never change them.
- R8: Writing 1 to register 0x00 bit 14 returns every register except the alarm register (0x01) to its reset value, parity enable included, even if bit 15 is set in the same write. Bit 14 always reads 0.
- R9: Alarm bits 15:12 of register 0x01 are sticky. Writing 1 clears a bit and writing 0 leaves it unchanged.
- R10: Register 0x02 bits 15:12 mask the matching alarm bits. `alarm_irq` is high exactly when some alarm bit is set and its mask bit is 0.
- R11: Writable bits by address: 0x02 F000, 0x03 7BE0, 0x04 03CF, 0x05 FFFC, 0x07 FE7F, 0x08 0FFF, 0x09 F3FF, 0x0A 007F, 0x0B FFFF. All other bits read as 0.
- R12: `reg_image[16*a +: 16]` equals the value a read of address `a` returns, for a = 0..11 (slice 6 is 0).
- R13: After reset every register reads 0, except the identification fields of register 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, mode 0 |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial read data to the host |
| alarm_irq | output | 1 | Active-high alarm request after masking |
| reg_image | output | 192 | Readable value of each register, 16 bits per address |

## Verification
A miscounted clock, a wrong address window or a stuck parity check shows up as an alarm bit in `reg_image` one system clock after the synchronised select edge, or as a register slice that changes when it should not. A wrong read-path state (a stale latch of the address, or a misaligned output shifter) shows up as a shifted or mixed-up word on MISO in the very frame that requested it. Soft-reset and mask faults appear on `reg_image` and `alarm_irq` one clock after the frame that triggers them.

// File: rtl/spirf_pkg.sv
package spirf_pkg;
  localparam int FRAME_BITS = 24;
  localparam int ADDR_BITS  = 6;
  localparam int WORD_BITS  = 16;
  localparam int NUM_REGS   = 12;
  localparam int IDX_BITS   = $clog2(NUM_REGS);
  localparam int CNT_BITS   = 5;
  // edge index (1-based) after which the address is complete
  localparam int ADDR_DONE  = 1 + ADDR_BITS;
  localparam int IMG_BITS   = NUM_REGS * WORD_BITS;

  localparam logic [ADDR_BITS-1:0] A_CTRL  = 6'h00;
  localparam logic [ADDR_BITS-1:0] A_ALARM = 6'h01;
  localparam int                   A_MASK  = 2;
  localparam int                   A_HOLE  = 6;

  localparam int B_PAR_EN  = 15;
  localparam int B_SRST    = 14;
  localparam int AL_PARITY = 15;
  localparam int AL_SHORT  = 14;
  localparam int AL_LONG   = 13;
  localparam int AL_ADDR   = 12;
  localparam logic [WORD_BITS-1:0] ALARM_FIELD = 16'hF000;

  typedef struct packed {
    logic                 rd;
    logic [ADDR_BITS-1:0] addr;
    logic [WORD_BITS-1:0] data;
    logic                 par;
  } frame_t;

  function automatic logic addr_ok(logic [ADDR_BITS-1:0] a);
    return (a < ADDR_BITS'(NUM_REGS)) && (a != ADDR_BITS'(A_HOLE));
  endfunction

  function automatic logic [WORD_BITS-1:0] wr_mask(int a);
    case (a)
      2:       return 16'hF000;
      3:       return 16'h7BE0;
      4:       return 16'h03CF;
      5:       return 16'hFFFC;
      7:       return 16'hFE7F;
      8:       return 16'h0FFF;
      9:       return 16'hF3FF;
      10:      return 16'h007F;
      11:      return 16'hFFFF;
      default: return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/spirf_sync.sv
module spirf_sync #(
  parameter int          W    = 3,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= IDLE;
      dout <= IDLE;
    end else begin
      meta <= din;
      dout <= meta;
    end
  end
endmodule

// File: rtl/spirf_shifter.sv
module spirf_shifter
  import spirf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk_s,
  input  logic                 csn_s,
  input  logic                 mosi_s,
  input  logic [WORD_BITS-1:0] rd_word,
  output logic [ADDR_BITS-1:0] rd_addr,
  output logic                 selected,
  output logic                 frame_done,
  output frame_t               frame,
  output logic [CNT_BITS-1:0]  frame_len,
  output logic                 miso
);
  logic                  sclk_q, csn_q;
  logic                  sclk_rise, sclk_fall, sel_start, sel_end;
  logic [FRAME_BITS-1:0] sr;
  logic [CNT_BITS-1:0]   cnt;
  logic [WORD_BITS-1:0]  osr;
  logic                  load_pend, rd_act;

  assign selected  = ~csn_s;
  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;
  assign sel_start = ~csn_s & csn_q;
  assign sel_end   = csn_s & ~csn_q;

  // one cycle after the address edge, sr[5:0] is the address, sr[6] the read flag
  assign rd_addr   = sr[ADDR_BITS-1:0];
  assign frame     = frame_t'(sr);
  assign frame_len = cnt;
  assign miso      = selected & rd_act & osr[WORD_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      csn_q      <= 1'b1;
      sr         <= '0;
      cnt        <= '0;
      osr        <= '0;
      load_pend  <= 1'b0;
      rd_act     <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      sclk_q     <= sclk_s;
      csn_q      <= csn_s;
      frame_done <= sel_end;
      load_pend  <= selected && sclk_rise && (cnt == CNT_BITS'(ADDR_DONE - 1));
      if (sel_start) begin
        sr     <= '0;
        cnt    <= '0;
        osr    <= '0;
        rd_act <= 1'b0;
      end else if (load_pend) begin
        osr    <= rd_word;
        rd_act <= sr[ADDR_BITS];
      end else if (selected && sclk_rise) begin
        sr <= {sr[FRAME_BITS-2:0], mosi_s};
        if (cnt != '1) cnt <= cnt + 1'b1;
      end else if (selected && sclk_fall && (cnt >= CNT_BITS'(ADDR_DONE + 1))) begin
        osr <= {osr[WORD_BITS-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spirf_regbank.sv
module spirf_regbank
  import spirf_pkg::*;
#(
  parameter logic [7:0] CHIP_ID = 8'h09,
  parameter logic [3:0] REV_ID  = 4'h3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_done,
  input  frame_t               frame,
  input  logic [CNT_BITS-1:0]  frame_len,
  input  logic [ADDR_BITS-1:0] rd_addr,
  output logic [WORD_BITS-1:0] rd_word,
  output logic [IMG_BITS-1:0]  image,
  output logic                 alarm_irq
);
  logic [WORD_BITS-1:0] view [NUM_REGS];
  logic                 par_en;
  logic [WORD_BITS-1:0] alarm, al_set, al_clr;
  logic                 len_ok, too_short, too_long, par_bad, a_ok;
  logic                 do_wr, wr_ctrl, srst;

  assign len_ok    = frame_len == CNT_BITS'(FRAME_BITS);
  assign too_short = frame_len <  CNT_BITS'(FRAME_BITS);
  assign too_long  = frame_len >  CNT_BITS'(FRAME_BITS);
  assign par_bad   = par_en && !(^frame);
  assign a_ok      = addr_ok(frame.addr);
  assign do_wr     = frame_done && len_ok && !par_bad && a_ok && !frame.rd;
  assign wr_ctrl   = do_wr && (frame.addr == A_CTRL);
  assign srst      = wr_ctrl && frame.data[B_SRST];

  always_comb begin
    al_set = '0;
    if (frame_done) begin
      al_set[AL_SHORT]  = too_short;
      al_set[AL_LONG]   = too_long;
      al_set[AL_PARITY] = len_ok && par_bad;
      al_set[AL_ADDR]   = len_ok && !a_ok;
    end
    al_clr = (do_wr && frame.addr == A_ALARM) ? (frame.data & ALARM_FIELD) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm  <= '0;
      par_en <= 1'b0;
    end else begin
      alarm <= (alarm & ~al_clr) | al_set;
      if (srst)         par_en <= 1'b0;
      else if (wr_ctrl) par_en <= frame.data[B_PAR_EN];
    end
  end

  for (genvar a = 0; a < NUM_REGS; a++) begin : g_reg
    if (a == 0) begin : g_ctrl
      assign view[a] = {par_en, 3'b000, CHIP_ID, REV_ID};
    end else if (a == 1) begin : g_alarm
      assign view[a] = alarm;
    end else if (a == A_HOLE) begin : g_hole
      assign view[a] = '0;
    end else begin : g_plain
      logic [WORD_BITS-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                      q <= '0;
        else if (srst)                                   q <= '0;
        else if (do_wr && frame.addr == ADDR_BITS'(a))   q <= frame.data & wr_mask(a);
      end
      assign view[a] = q;
    end
    assign image[a*WORD_BITS +: WORD_BITS] = view[a];
  end

  assign rd_word   = addr_ok(rd_addr) ? view[rd_addr[IDX_BITS-1:0]] : '0;
  assign alarm_irq = |(alarm & ~view[A_MASK]);
endmodule

// File: rtl/spirf_top.sv
module spirf_top
  import spirf_pkg::*;
#(
  parameter logic [7:0] CHIP_ID = 8'h09,
  parameter logic [3:0] REV_ID  = 4'h3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                cs_n,
  input  logic                mosi,
  output logic                miso,
  output logic                alarm_irq,
  output logic [IMG_BITS-1:0] reg_image
);
  logic [2:0]           pins_s;
  logic [WORD_BITS-1:0] rd_word;
  logic [ADDR_BITS-1:0] rd_addr;
  logic                 selected, frame_done;
  frame_t               frame;
  logic [CNT_BITS-1:0]  frame_len;

  spirf_sync #(.W(3), .IDLE(3'b010)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({sclk, cs_n, mosi}),
    .dout (pins_s)
  );

  spirf_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (pins_s[2]),
    .csn_s     (pins_s[1]),
    .mosi_s    (pins_s[0]),
    .rd_word   (rd_word),
    .rd_addr   (rd_addr),
    .selected  (selected),
    .frame_done(frame_done),
    .frame     (frame),
    .frame_len (frame_len),
    .miso      (miso)
  );

  spirf_regbank #(.CHIP_ID(CHIP_ID), .REV_ID(REV_ID)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_done(frame_done),
    .frame     (frame),
    .frame_len (frame_len),
    .rd_addr   (rd_addr),
    .rd_word   (rd_word),
    .image     (reg_image),
    .alarm_irq (alarm_irq)
  );
endmodule

// File: rtl/spirf_checker.sv
module spirf_checker
  import spirf_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                frame_done,
  input logic [CNT_BITS-1:0] frame_len,
  input logic                selected,
  input logic                miso,
  input logic [IMG_BITS-1:0] image
);
  localparam logic [CNT_BITS-1:0] FULL = CNT_BITS'(FRAME_BITS);

  // R1: register contents only move at a frame end
  a_r1_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(image));

  // R2: nothing on MISO while deselected
  a_r2_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !selected |-> !miso);

  // R4: short frame raises its alarm
  a_r4_short_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && frame_len < FULL |=> image[WORD_BITS + AL_SHORT]);

  // R5: long frame raises its alarm
  a_r5_long_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && frame_len > FULL |=> image[WORD_BITS + AL_LONG]);

  // R4, R5: a bad-length frame leaves every non-alarm register untouched
  a_r4_r5_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && frame_len != FULL |=>
      $stable(image[IMG_BITS-1:2*WORD_BITS]) && $stable(image[WORD_BITS-1:0]));

  // R9: a bad-length frame cannot clear any alarm bit
  a_r9_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && frame_len != FULL |=>
      ((image[2*WORD_BITS-1:WORD_BITS] & $past(image[2*WORD_BITS-1:WORD_BITS]))
        == $past(image[2*WORD_BITS-1:WORD_BITS])));
endmodule

bind spirf_top spirf_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_done(frame_done),
  .frame_len (frame_len),
  .selected  (selected),
  .miso      (miso),
  .image     (reg_image)
);

// File: tb/spirf_top_test.sv
module spirf_top_test;
  localparam int CLK_NS = 10;
  localparam int HALF   = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sclk = 1'b0;
  logic         cs_n = 1'b1;
  logic         mosi = 1'b0;
  logic         miso, alarm_irq;
  logic [191:0] reg_image;

  int checks = 0;
  int fails  = 0;
  bit par_on = 0;
  bit ended  = 0;

  spirf_top uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .alarm_irq(alarm_irq), .reg_image(reg_image)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [15:0] emask(int a);
    case (a)
      2: return 16'hF000;  3: return 16'h7BE0;  4: return 16'h03CF;
      5: return 16'hFFFC;  7: return 16'hFE7F;  8: return 16'h0FFF;
      9: return 16'hF3FF; 10: return 16'h007F; 11: return 16'hFFFF;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [23:0] mk(bit rd, logic [5:0] a, logic [15:0] d);
    logic [23:0] f;
    f = {rd, a, d, 1'b0};
    if (par_on) f[0] = ~(^f[23:1]);
    return f;
  endfunction

  function automatic logic [15:0] img(int a);
    return reg_image[a*16 +: 16];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [23:0] tx, input int n, output logic [23:0] rx);
    rx = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      mosi = (i < 24) ? tx[23-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (i < 24) rx[23-i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    logic [23:0] rx;
    xfer(mk(1'b0, a, d), 24, rx);
  endtask

  task automatic rd(logic [5:0] a, output logic [15:0] v, output logic [23:0] raw);
    xfer(mk(1'b1, a, 16'h0000), 24, raw);
    v = raw[16:1];
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0]  v;
    logic [23:0]  raw, tx;
    logic [191:0] snap;
    logic [15:0]  pats [4];
    pats[0] = 16'hFFFF; pats[1] = 16'hA5A5; pats[2] = 16'h5A5A; pats[3] = 16'h0000;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R13: reset state
    for (int a = 0; a < 12; a++)
      chk("R13 reset value", img(a), (a == 0) ? 16'h0093 : 16'h0000);
    chk("R13 irq idle", alarm_irq, 0);
    chk("R2 miso idle", miso, 0);

    // R11, R12, R2: sweep every plain register with several patterns
    for (int a = 2; a < 12; a++) begin
      if (a == 6) continue;
      for (int p = 0; p < 4; p++) begin
        wr(6'(a), pats[p]);
        chk("R11 R12 image after write", img(a), pats[p] & emask(a));
        rd(6'(a), v, raw);
        chk("R2 R11 serial readback", v, pats[p] & emask(a));
        chk("R2 miso zero outside data bits", {raw[23:17], raw[0]}, 0);
      end
    end

    // R2: write frames return nothing on MISO
    xfer(mk(1'b0, 6'd3, 16'hFFFF), 24, raw);
    chk("R2 miso quiet in write frame", raw, 0);
    for (int a = 4; a < 12; a++) if (a != 6) wr(6'(a), 16'hFFFF);
    snap = reg_image;

    // R3: unimplemented addresses
    wr(6'd6, 16'hFFFF);
    wr(6'd12, 16'hFFFF);
    wr(6'd63, 16'hFFFF);
    chk("R3 no write to bad address", {reg_image[191:32], reg_image[15:0]},
        {snap[191:32], snap[15:0]});
    rd(6'd6, v, raw);
    chk("R3 hole reads zero", v, 0);
    rd(6'd1, v, raw);
    chk("R3 address alarm", v, 16'h1000);

    // R10: masking of the alarm output
    chk("R10 irq unmasked", alarm_irq, 1);
    wr(6'd2, 16'h1000);
    chk("R10 irq masked", alarm_irq, 0);
    wr(6'd2, 16'h0000);
    chk("R10 irq unmasked again", alarm_irq, 1);

    // R9: write-one-to-clear
    wr(6'd1, 16'h0000);
    rd(6'd1, v, raw);
    chk("R9 zero leaves alarm", v, 16'h1000);
    wr(6'd1, 16'h1000);
    rd(6'd1, v, raw);
    chk("R9 one clears alarm", v, 16'h0000);
    chk("R9 irq cleared", alarm_irq, 0);

    // R4: short frame
    xfer(mk(1'b0, 6'd11, 16'h1234), 20, raw);
    chk("R4 short frame dropped", img(11), 16'hFFFF);
    rd(6'd1, v, raw);
    chk("R4 short alarm", v, 16'h4000);
    wr(6'd1, 16'h4000);

    // R5: long frame
    xfer(mk(1'b0, 6'd11, 16'h1234), 26, raw);
    chk("R5 long frame dropped", img(11), 16'hFFFF);
    rd(6'd1, v, raw);
    chk("R5 long alarm", v, 16'h2000);
    wr(6'd1, 16'h2000);
    rd(6'd1, v, raw);
    chk("R9 cleared after R5", v, 16'h0000);

    // R6: parity
    wr(6'd0, 16'h8000);
    par_on = 1;
    rd(6'd0, v, raw);
    chk("R6 parity enable reads back", v, 16'h8093);
    tx = mk(1'b0, 6'd11, 16'h00AA) ^ 24'h000001;
    xfer(tx, 24, raw);
    chk("R6 bad parity blocks write", img(11), 16'hFFFF);
    rd(6'd1, v, raw);
    chk("R6 parity alarm", v, 16'h8000);
    wr(6'd11, 16'h00AA);
    chk("R6 good parity writes", img(11), 16'h00AA);
    wr(6'd1, 16'h8000);
    wr(6'd0, 16'h0000);
    par_on = 0;
    xfer(mk(1'b0, 6'd11, 16'h0155) | 24'h000001, 24, raw);
    chk("R6 bit0 ignored (set)", img(11), 16'h0155);
    xfer(mk(1'b0, 6'd11, 16'h0156), 24, raw);
    chk("R6 bit0 ignored (clear)", img(11), 16'h0156);
    rd(6'd1, v, raw);
    chk("R6 no alarm when disabled", v, 16'h0000);

    // R7: identification is read-only
    wr(6'd0, 16'h0FFF);
    rd(6'd0, v, raw);
    chk("R7 id fields fixed", v, 16'h0093);
    chk("R7 id in image", img(0), 16'h0093);

    // R8: soft reset
    wr(6'd2, 16'hF000);
    wr(6'd6, 16'h0000);
    wr(6'd0, 16'hC000);
    for (int a = 0; a < 12; a++) begin
      if (a == 1) chk("R8 alarm kept", img(a), 16'h1000);
      else        chk("R8 register reset", img(a), (a == 0) ? 16'h0093 : 16'h0000);
    end
    rd(6'd0, v, raw);
    chk("R8 reset bit reads zero", v, 16'h0093);
    chk("R8 R10 mask reset raises irq", alarm_irq, 1);

    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule